// File: doc/BRIEF.md
# Zero-Crossing Gated Gain Updater

This block sits between a host-written gain register and the switch network of one audio volume channel. A chip instantiates it once per channel. It receives an 8-bit gain code with a one-cycle write strobe. It decides in which clock cycle that code becomes the active code that drives the switches.

With the zero-crossing option off, a write takes effect on the next clock edge. With the option on, a write that changes the code waits. It is applied when the channel's input polarity bit shows a rising transition. If no rising transition comes within a fixed number of timebase ticks, it is applied anyway. The polarity bit comes from an analog comparator and is asynchronous, so it passes through a synchronizer first.

Besides the active code, the block reports a mute flag for code zero and the gain as a signed count of half-decibel steps.

Top module: `zc_gain_updater`

## Requirements
- R1: While reset is asserted and after its release, the active code is 0, mute is 1 and the half-dB gain output is 0.
- R2: With zc_en low, a code written with wr_stb appears on act_code after the next rising clock edge.
- R3: For an active code N from 1 to 255, gain_hd is the 9-bit two's-complement value N − 192, which is twice the gain in dB: +63 for N = 255 and −191 for N = 1.
- R4: Active code 0 gives mute = 1 and gain_hd = 0. Any nonzero active code gives mute = 0.
- R5: With zc_en high, a written code that differs from the active code is held pending. It is applied when pol_in goes from low to high. After two synchronizer flops and an edge flop, that happens on the third rising clock edge after the first edge that samples pol_in high.
- R6: A high-to-low transition of pol_in never applies a pending code.
- R7: If no rising crossing arrives, the pending code is applied at the clock edge that samples the 16th tick pulse after the write. The count is the parameter TIMEOUT_TICKS, 16 by default.
- R8: A write that arrives while a code is pending replaces the pending code and restarts the tick count from zero.
- R9: With zc_en high, a write of a code equal to the active code leaves act_code unchanged and cancels any pending code.
- R10: When a write coincides with a rising crossing or with the expiring tick, the write takes priority. That crossing or tick is not applied, and the newly written code waits for a later event.
- R11: If zc_en goes low while a code is pending, the pending code is applied on the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle timebase pulse, one per millisecond in the default set-up |
| zc_en | input | 1 | Zero-crossing gating enable |
| wr_stb | input | 1 | Write strobe for wr_code |
| wr_code | input | 8 | Newly written gain code |
| pol_in | input | 1 | Asynchronous input-polarity bit from the channel comparator |
| act_code | output | 8 | Active gain code driving the switch network |
| mute | output | 1 | High when the active code is 0 |
| gain_hd | output | 9 | Signed gain of the active code in half-dB units |

## Verification
Two events can fall in the same clock cycle: a host write, and the event that releases a pending code, which is either a synchronized rising crossing or the final timeout tick. The bench provokes a crossing collision by timing the write strobe so that it is sampled at the same edge as the edge flop's rising-transition condition. It provokes a timeout collision by raising the write strobe together with the 16th tick pulse. In both cases the active code must keep its old value at that edge. The new code must then survive a full set of ticks less one without being applied, and be applied exactly on the following tick. That shows the colliding event was discarded and the timeout count was restarted.

// File: rtl/zcg_pkg.sv
package zcg_pkg;
    localparam int GCODE_W = 8;
    localparam int HD_W    = GCODE_W + 1;
    // Twice the top gain in dB (+31.5 dB at full-scale code)
    localparam int TOP_HD  = 63;

    typedef logic [GCODE_W-1:0] gcode_t;

    typedef struct packed {
        gcode_t act;
        gcode_t pcode;
        logic   pend;
    } upd_state_t;
endpackage

// File: rtl/zcg_pol_sync.sv
module zcg_pol_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    // chain_q[STAGES-1] is the synchronized level, chain_q[STAGES] its previous value
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/zcg_tick_timer.sv
module zcg_tick_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          last_tick;

    assign last_tick = (cnt_q == CW'(LIMIT - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (run && tick && !last_tick)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run & tick & last_tick;

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(LIMIT));
endmodule

// File: rtl/zcg_gain_map.sv
module zcg_gain_map
    import zcg_pkg::*;
(
    input  gcode_t                  code,
    output logic                    mute,
    output logic signed [HD_W-1:0]  hd
);
    localparam int OFFSET = (2 ** GCODE_W - 1) - TOP_HD;

    int raw;

    always_comb begin
        raw  = int'(code) - OFFSET;
        mute = (code == '0);
        hd   = mute ? '0 : raw[HD_W-1:0];
    end
endmodule

// File: rtl/zc_gain_updater.sv
module zc_gain_updater
    import zcg_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 16,
    parameter int SYNC_STAGES   = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic                    zc_en,
    input  logic                    wr_stb,
    input  logic [GCODE_W-1:0]      wr_code,
    input  logic                    pol_in,
    output logic [GCODE_W-1:0]      act_code,
    output logic                    mute,
    output logic signed [HD_W-1:0]  gain_hd
);
    upd_state_t st_d, st_q;
    logic       rise;
    logic       expired;
    logic       release_now;

    zcg_pol_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pol_in),
        .rise     (rise)
    );

    zcg_tick_timer #(.LIMIT(TIMEOUT_TICKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (wr_stb | ~st_q.pend),
        .run     (st_q.pend),
        .tick    (tick),
        .expired (expired)
    );

    assign release_now = !zc_en || rise || expired;

    always_comb begin
        st_d = st_q;
        if (wr_stb) begin
            if (!zc_en) begin
                st_d.act  = wr_code;
                st_d.pend = 1'b0;
            end else if (wr_code == st_q.act) begin
                st_d.pend = 1'b0;
            end else begin
                st_d.pend  = 1'b1;
                st_d.pcode = wr_code;
            end
        end else if (st_q.pend && release_now) begin
            st_d.act  = st_q.pcode;
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_code = st_q.act;

    zcg_gain_map u_map (
        .code (st_q.act),
        .mute (mute),
        .hd   (gain_hd)
    );

    // R2
    direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !zc_en) |=> (act_code == $past(wr_code)));

    // R5
    change_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_code != $past(act_code)) |-> $past(wr_stb || st_q.pend));

    // R10
    hold_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && zc_en && !wr_stb && !rise && !expired) |=> $stable(act_code));

    // R9
    same_code_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && zc_en && wr_code == act_code) |=> (!st_q.pend && $stable(act_code)));
endmodule

// File: tb/zc_gain_updater_bench.sv
module zc_gain_updater_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       zc_en = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_code = '0;
    logic       pol_in = 1'b0;
    logic [7:0] act_code;
    logic       mute;
    logic signed [8:0] gain_hd;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    zc_gain_updater u_zc_gain_updater (
        .clk(clk), .rst_n(rst_n), .tick(tick), .zc_en(zc_en),
        .wr_stb(wr_stb), .wr_code(wr_code), .pol_in(pol_in),
        .act_code(act_code), .mute(mute), .gain_hd(gain_hd)
    );

    task automatic check_val(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write(input logic [7:0] c);
        wr_code = c;
        wr_stb  = 1'b1;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
    endtask

    // raise pol_in and wait until just after the edge that applies a pending code
    task automatic crossing();
        pol_in = 1'b1;
        cycles(3);
    endtask

    function automatic int exp_hd(input int n);
        return (n == 0) ? 0 : n - 192;
    endfunction

    initial begin
        #1000000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cycles(3);
        // R1 during reset
        check_val("R1 act in reset", int'(act_code), 0);
        rst_n = 1'b1;
        cycles(2);
        check_val("R1 act", int'(act_code), 0);
        check_val("R1 mute", int'(mute), 1);
        check_val("R1 gain", int'(gain_hd), 0);

        // R2 R3 R4: exhaustive sweep, immediate mode
        for (int n = 0; n < 256; n++) begin
            write(8'(n));
            check_val("R2 act", int'(act_code), n);
            check_val("R4 mute", int'(mute), (n == 0) ? 1 : 0);
            check_val("R3 gain", int'(gain_hd), exp_hd(n));
        end
        write(8'd0);
        check_val("R4 mute back", int'(mute), 1);
        write(8'd100);

        // R5 rising crossing
        zc_en = 1'b1;
        write(8'd200);
        cycles(4);
        check_val("R5 held", int'(act_code), 100);
        pol_in = 1'b1;
        cycles(2);
        check_val("R5 before third edge", int'(act_code), 100);
        cycles(1);
        check_val("R5 applied", int'(act_code), 200);
        check_val("R3 gain zc", int'(gain_hd), 8);

        // R6 falling edge does nothing
        write(8'd50);
        pol_in = 1'b0;
        cycles(6);
        check_val("R6 falling ignored", int'(act_code), 200);

        // R7 timeout (R8 not involved: pending 50 since above)
        ticks(15);
        check_val("R7 before timeout", int'(act_code), 200);
        ticks(1);
        check_val("R7 timeout applied", int'(act_code), 50);

        // R8 replace and restart
        write(8'd10);
        ticks(10);
        write(8'd20);
        ticks(15);
        check_val("R8 restarted", int'(act_code), 50);
        ticks(1);
        check_val("R8 replaced code", int'(act_code), 20);

        // R9 same code cancels pending
        write(8'd77);
        write(8'd20);
        crossing();
        check_val("R9 crossing after cancel", int'(act_code), 20);
        pol_in = 1'b0;
        ticks(17);
        check_val("R9 timeout after cancel", int'(act_code), 20);
        write(8'd20);
        check_val("R9 same code no change", int'(act_code), 20);

        // R10 write coincides with crossing
        write(8'd30);
        cycles(2);
        pol_in = 1'b1;
        cycles(2);
        wr_code = 8'd40;
        wr_stb  = 1'b1;
        @(negedge clk);
        wr_stb  = 1'b0;
        check_val("R10 crossing lost to write", int'(act_code), 20);
        cycles(5);
        check_val("R10 still pending", int'(act_code), 20);
        ticks(16);
        check_val("R10 new code by timeout", int'(act_code), 40);
        pol_in = 1'b0;
        cycles(3);

        // R10 write coincides with final tick
        write(8'd60);
        ticks(15);
        wr_code = 8'd61;
        wr_stb  = 1'b1;
        tick    = 1'b1;
        @(negedge clk);
        wr_stb  = 1'b0;
        tick    = 1'b0;
        @(negedge clk);
        check_val("R10 tick lost to write", int'(act_code), 40);
        ticks(15);
        check_val("R10 count restarted", int'(act_code), 40);
        ticks(1);
        check_val("R10 applied after restart", int'(act_code), 61);

        // R11 enable drops while pending
        write(8'd255);
        cycles(2);
        check_val("R11 pending", int'(act_code), 61);
        zc_en = 1'b0;
        @(negedge clk);
        check_val("R11 applied", int'(act_code), 255);
        check_val("R3 top gain", int'(gain_hd), 63);
        check_val("R4 unmuted", int'(mute), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule